// File: doc/BRIEF.md
# Chip-Select Bank Strobe Timing Generator

This block runs the strobe sequence of one external memory access at a time. A requester presents a bank index, a read/write flag and a start strobe, together with the option bits that belong to that bank. When the engine is idle it accepts the request and produces the active-low chip-select, output-enable and write/byte-enable strobes for the access. It ends the access with a one-clock transfer-acknowledge pulse. The data path, address decoding across banks and bus arbitration sit outside the block.

Five option bits shape each access. A wait-state count stretches the access. An early-negate bit pulls strobes back one cycle before the end. A relaxed-timing bit adds cycles. A nonzero address-to-select field holds chip-select back after the access starts. An extended-hold bit inserts a dead cycle after a read, so the device has time to release the data bus. The block remembers the bank and direction of the previous access to decide when that dead cycle is needed. During an access it reports the number of the current cycle.

Top module: `cs_bank_timer`

## Requirements
- R1: While reset is asserted and after it is released, `cs_n`, `oe_n` and `we_n` are 1, `ack` is 0, `rdy` is 1 and `cyc_cnt` is 0.
- R2: An access is L cycles long, numbered 1..L, starting in the cycle after acceptance. With `opt_acs` = 00, `opt_early` = 0 and `opt_relax` = 0, L = 2 + `opt_waits`, `cs_n` is low in cycles 1..L, and `ack` is high in cycle L only.
- R3: For a write with `opt_early` = 1, `opt_relax` = 0 and `opt_acs` = 00: L = 2 + `opt_waits`, `we_n` is low in cycles 1..L-1, and `cs_n` stays low through cycle L.
- R4: When `opt_relax` = 1 and `opt_early` = 1, L grows by one cycle, for a read or a write. With `opt_acs` = 00 a write then lasts 3 + `opt_waits` cycles and `we_n` is low in cycles 1..L-1.
- R5: With `opt_acs` = 00, `opt_relax` does not delay strobe assertion: `cs_n` and `we_n` (or `oe_n`) go low in cycle 1. With `opt_early` = 0, relaxed timing leaves L unchanged.
- R6: With `opt_acs` nonzero, strobe assertion is delayed by D cycles (D = 1, or 2 when `opt_relax` = 1), and L grows by D. The strobes go low in cycle 1+D. If `opt_early` = 1 as well, `cs_n` and `oe_n` go high in cycle L; otherwise they stay low through cycle L.
- R7: `oe_n` is low only during reads and exactly when `cs_n` is low. `we_n` is low only during writes. The two are never low together.
- R8: If the previous access was a read with `opt_hold_rd` = 1, a new access is preceded by one dead cycle, in which `rdy` is 0 and all strobes are inactive. This applies when the new access is a write or is to a different `req_bank`. A read to the same bank, or any access after a write or after a read with `opt_hold_rd` = 0, has no dead cycle.
- R9: `rdy` is 1 only when no access or dead cycle is in progress, and a request is taken only at a clock edge where `req` and `rdy` are both 1. A request held high during an access is stalled and starts after one idle cycle; it is not lost.
- R10: `cyc_cnt` equals k during cycle k of an access, and 0 during idle and dead cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, held until taken |
| req_bank | input | BANK_W | Bank index of the request |
| req_wr | input | 1 | 1 = write, 0 = read |
| opt_hold_rd | input | 1 | Extended hold after a read to this bank |
| opt_relax | input | 1 | Relaxed timing |
| opt_early | input | 1 | Early strobe negation |
| opt_acs | input | 2 | Address-to-chip-select delay field, 00 = none |
| opt_waits | input | WS_W | Wait-state count |
| rdy | output | 1 | Engine idle, request can be taken |
| cs_n | output | 1 | Chip-select, active low |
| oe_n | output | 1 | Output-enable, active low |
| we_n | output | 1 | Write/byte-enable, active low |
| ack | output | 1 | Transfer acknowledge, one cycle |
| cyc_cnt | output | WS_W+3 | Current access cycle number |

## Verification
The bench sweeps the option bits, and a design that mixes them up shows a strobe one cycle off. Examples are relaxed timing that adds a cycle without early negation, a chip-select that drops early while the delay field is 00, and a delayed select that also delays the acknowledge by the wrong amount. The dead cycle after a read is tested in both directions. It must appear for a write and for a different bank, and it must not appear for a same-bank read or after a bank without the hold bit; a wrong model would shift every later strobe by one cycle in either direction. Requests held through a busy period check that a stalled start is neither dropped nor started early.

// File: rtl/cs_bank_timer.sv
module cs_bank_timer #(
  parameter int BANK_W = 3,
  parameter int WS_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [BANK_W-1:0] req_bank,
  input  logic              req_wr,
  input  logic              opt_hold_rd,
  input  logic              opt_relax,
  input  logic              opt_early,
  input  logic [1:0]        opt_acs,
  input  logic [WS_W-1:0]   opt_waits,
  output logic              rdy,
  output logic              cs_n,
  output logic              oe_n,
  output logic              we_n,
  output logic              ack,
  output logic [WS_W+2:0]   cyc_cnt
);
  localparam int CNT_W = WS_W + 3;

  typedef enum logic [1:0] {S_IDLE, S_HOLD, S_ACC} state_t;
  state_t state;

  logic [CNT_W-1:0]  cnt;
  logic              c_wr, c_relax, c_early, c_acs_nz;
  logic [WS_W-1:0]   c_waits;
  logic              l_vld, l_rd, l_hold;
  logic [BANK_W-1:0] l_bank;

  logic [CNT_W-1:0] dly, len, cs_on, cs_off, we_off;
  logic             take, need_hold, in_acc, in_cs, last;

  assign dly    = c_acs_nz ? (c_relax ? CNT_W'(2) : CNT_W'(1)) : '0;
  assign len    = CNT_W'(2) + CNT_W'(c_waits) + dly + CNT_W'(c_relax & c_early);
  assign cs_on  = CNT_W'(1) + dly;
  assign cs_off = (c_early && c_acs_nz) ? len - CNT_W'(1) : len;
  assign we_off = c_early ? len - CNT_W'(1) : len;

  assign in_acc = (state == S_ACC);
  assign last   = in_acc && (cnt == len);
  assign in_cs  = in_acc && (cnt >= cs_on) && (cnt <= cs_off);

  assign rdy     = (state == S_IDLE);
  assign take    = rdy && req;
  assign cs_n    = !in_cs;
  assign oe_n    = !(in_cs && !c_wr);
  assign we_n    = !(in_acc && c_wr && (cnt >= cs_on) && (cnt <= we_off));
  assign ack     = last;
  assign cyc_cnt = cnt;

  assign need_hold = l_vld && l_rd && l_hold && (req_wr || (req_bank != l_bank));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      c_wr     <= 1'b0;
      c_relax  <= 1'b0;
      c_early  <= 1'b0;
      c_acs_nz <= 1'b0;
      c_waits  <= '0;
    end else begin
      case (state)
        S_IDLE: if (take) begin
          c_wr     <= req_wr;
          c_relax  <= opt_relax;
          c_early  <= opt_early;
          c_acs_nz <= (opt_acs != 2'b00);
          c_waits  <= opt_waits;
          if (need_hold) state <= S_HOLD;
          else begin
            state <= S_ACC;
            cnt   <= CNT_W'(1);
          end
        end
        S_HOLD: begin
          state <= S_ACC;
          cnt   <= CNT_W'(1);
        end
        S_ACC: begin
          if (last) begin
            state <= S_IDLE;
            cnt   <= '0;
          end else cnt <= cnt + CNT_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_vld  <= 1'b0;
      l_rd   <= 1'b0;
      l_hold <= 1'b0;
      l_bank <= '0;
    end else if (take) begin
      l_vld  <= 1'b1;
      l_rd   <= !req_wr;
      l_hold <= opt_hold_rd;
      l_bank <= req_bank;
    end
  end
endmodule

module cs_bank_timer_chk #(
  parameter int WS_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rdy,
  input logic            cs_n,
  input logic            oe_n,
  input logic            we_n,
  input logic            ack,
  input logic [WS_W+2:0] cyc_cnt
);
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (cs_n && oe_n && we_n && !ack && rdy));

  a_r2_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (!ack && rdy));

  a_r7_oe_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));

  a_r7_oe_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !cs_n);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> (cs_n && oe_n && we_n && !ack && cyc_cnt == '0));

  a_r10_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_cnt != '0 && !ack) |=> (cyc_cnt == $past(cyc_cnt) + 1'b1));
endmodule

bind cs_bank_timer cs_bank_timer_chk #(.WS_W(WS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rdy(rdy), .cs_n(cs_n), .oe_n(oe_n),
  .we_n(we_n), .ack(ack), .cyc_cnt(cyc_cnt)
);

// File: tb/sim_cs_bank_timer.sv
module sim_cs_bank_timer;
  localparam int BANK_W = 3;
  localparam int WS_W   = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, req_wr = 1'b0;
  logic [BANK_W-1:0] req_bank = '0;
  logic opt_hold_rd = 1'b0, opt_relax = 1'b0, opt_early = 1'b0;
  logic [1:0] opt_acs = 2'b00;
  logic [WS_W-1:0] opt_waits = '0;
  logic rdy, cs_n, oe_n, we_n, ack;
  logic [WS_W+2:0] cyc_cnt;

  always #4 clk = ~clk;

  cs_bank_timer #(.BANK_W(BANK_W), .WS_W(WS_W)) u0 (.*);

  typedef struct {
    logic [4:0] v;
    int         cnt;
    string      tag;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit started = 0, done = 0;

  bit l_vld = 0, l_rd = 0, l_hold = 0;
  int l_bank = 0;

  task automatic push(input logic [4:0] v, input int c, input string tag);
    item_t it;
    it.v = v; it.cnt = c; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic push_acc(input string tag, input bit wr, input bit relax,
                          input bit early, input int acs, input int w);
    int d, len, cs_on, cs_off, we_off;
    bit cs, we;
    d      = (acs != 0) ? (relax ? 2 : 1) : 0;
    len    = 2 + w + d + ((relax && early) ? 1 : 0);
    cs_on  = 1 + d;
    cs_off = (early && acs != 0) ? len - 1 : len;
    we_off = early ? len - 1 : len;
    for (int k = 1; k <= len; k++) begin
      cs = (k >= cs_on) && (k <= cs_off);
      we = wr && (k >= cs_on) && (k <= we_off);
      push({!cs, !(cs && !wr), !we, k == len, 1'b0}, k, tag);
    end
  endtask

  task automatic do_acc(input string tag, input int bank, input bit wr,
                        input bit hold, input bit relax, input bit early,
                        input int acs, input int w, input bit stall);
    bit nh;
    if (!stall) while (!rdy) @(negedge clk);
    req = 1'b1; req_bank = BANK_W'(bank); req_wr = wr;
    opt_hold_rd = hold; opt_relax = relax; opt_early = early;
    opt_acs = 2'(acs); opt_waits = WS_W'(w);
    nh = l_vld && l_rd && l_hold && (wr || bank != l_bank);
    if (stall) push(5'b11101, 0, "R9");
    if (nh) push(5'b11100, 0, "R8");
    push_acc(tag, wr, relax, early, acs, w);
    l_vld = 1; l_rd = !wr; l_hold = hold; l_bank = bank;
    if (stall) begin
      @(negedge clk);
      while (!rdy) @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin : monitor
    item_t e;
    forever begin
      @(posedge clk);
      #2;
      if (started && !done) begin
        if (q.size() != 0) e = q.pop_front();
        else begin e.v = 5'b11101; e.cnt = 0; e.tag = "R9"; end
        n_chk++;
        if ({cs_n, oe_n, we_n, ack, rdy} !== e.v) begin
          n_fail++;
          $display("FAIL %s strobes {cs_n,oe_n,we_n,ack,rdy} actual=%b expected=%b",
                   e.tag, {cs_n, oe_n, we_n, ack, rdy}, e.v);
        end
        n_chk++;
        if (int'(cyc_cnt) != e.cnt) begin
          n_fail++;
          $display("FAIL R10 cyc_cnt actual=%0d expected=%0d", cyc_cnt, e.cnt);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    n_chk++;
    if ({cs_n, oe_n, we_n, ack, rdy} !== 5'b11101 || cyc_cnt != 0) begin
      n_fail++;
      $display("FAIL R1 in reset actual=%b/%0d expected=11101/0",
               {cs_n, oe_n, we_n, ack, rdy}, cyc_cnt);
    end
    rst_n = 1'b1;
    @(negedge clk);
    started = 1;
    // do_acc(tag, bank, wr, hold, relax, early, acs, waits, stall)
    do_acc("R2",    1, 0, 0, 0, 0, 0, 0, 0);
    do_acc("R2",    1, 0, 0, 0, 0, 0, 3, 0);
    do_acc("R3/R7", 2, 1, 0, 0, 1, 0, 0, 0);
    do_acc("R3",    2, 1, 0, 0, 1, 0, 2, 0);
    do_acc("R4/R5", 2, 1, 0, 1, 1, 0, 0, 0);
    do_acc("R4",    2, 0, 0, 1, 1, 0, 1, 0);
    do_acc("R5",    2, 1, 0, 1, 0, 0, 1, 0);
    do_acc("R6",    1, 0, 0, 0, 0, 1, 0, 0);
    do_acc("R6",    1, 1, 0, 1, 1, 2, 0, 0);
    do_acc("R6/R7", 1, 0, 0, 0, 1, 1, 0, 0);
    do_acc("R6",    1, 0, 0, 1, 0, 3, 2, 0);
    do_acc("R8",    3, 0, 1, 0, 0, 0, 0, 0);
    do_acc("R8",    3, 0, 1, 0, 0, 0, 1, 0);
    do_acc("R8",    3, 1, 0, 0, 0, 0, 0, 0);
    do_acc("R8",    4, 0, 1, 0, 0, 0, 0, 0);
    do_acc("R8",    5, 0, 0, 0, 0, 0, 0, 0);
    do_acc("R8",    5, 1, 0, 0, 1, 0, 0, 0);
    do_acc("R9",    1, 1, 0, 0, 0, 0, 2, 0);
    do_acc("R9",    1, 0, 0, 0, 0, 0, 0, 1);
    do_acc("R8/R9", 6, 0, 1, 0, 0, 0, 1, 0);
    do_acc("R8/R9", 6, 1, 0, 1, 1, 1, 0, 1);
    while (q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule